// File: doc/BRIEF.md
# Bandwidth-Gap Lane Sorter

This block sits at the entry of a virtual-link transmit scheduler. Four request ports each present a 32-bit word. The top byte carries the link's bandwidth-allocation gap (BAG) as a one-hot power of two. The lower 24 bits carry the link identifier.

A polling pointer visits the ports in a fixed rotation, one port per clock. For the port it visits, the block decodes the gap field and copies the identifier onto the output lane reserved for that gap value, with a one-cycle write strobe. The per-gap buffers behind the lanes therefore receive requests already sorted by rate.

The gap byte of every port is also mirrored on its own output on every clock, so a downstream stage can see which rate each port is asking for.

Top module: `bag_lane_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every write strobe, every lane identifier, every mirrored gap byte and the polling pointer to zero.
- R2: After reset is released, the n-th rising edge (n = 0, 1, 2, ...) examines port n mod 4, in the order 0, 1, 2, 3, 0, ... The result of that examination is visible on the outputs right after that edge.
- R3: Port p's word is `port_word_i[p*32 +: 32]`. Its bits 31..24 are the gap field and bits 23..0 are the identifier.
- R4: When the examined port's gap field equals 2^k (k = 0..7), lane k is written. Its identifier `lane_id_o[k*24 +: 24]` takes the examined identifier, and `lane_wr_o[k]` is high for the cycle that follows the examining edge.
- R5: At most one bit of `lane_wr_o` is high in any cycle. A strobe is never held beyond the cycle of the write it reports.
- R6: A lane that is not written keeps its last identifier.
- R7: `port_bag_o[p*8 +: 8]` shows bits 31..24 of port p as sampled at the previous rising edge, for all four ports on every cycle.
- R8: A gap field that is not one-hot, including zero (for example 8'h00, 8'h03, 8'hFF), writes no lane and changes no lane identifier.
- R9: A valid word held steady on a single port produces its lane write within four rising edges of being applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| port_word_i | input | 128 | Four request words, port p at bits p*32 +: 32 |
| port_bag_o | output | 32 | Registered gap byte per port, port p at bits p*8 +: 8 |
| lane_id_o | output | 192 | Identifier per lane, lane k at bits k*24 +: 24 |
| lane_wr_o | output | 8 | Write strobe per lane, bit k for gap value 2^k |

## Verification
The bench aims at four kinds of fault:
- Gap values that are not one-hot, such as zero, two bits set or all ones. A decoder that priority-encodes instead of checking one-hotness would write a lane for these.
- Every gap value placed on every port in turn. A pointer that starts on the wrong port or skips one would write the right lane in the wrong cycle.
- A steady word on a single port. A rotation longer than four cycles would miss the four-edge service bound.
- A reset applied in the middle of traffic. A block that clears the lanes but not the pointer would restart its rotation on the wrong port.

// File: rtl/bag_arb_pkg.sv
package bag_arb_pkg;

    // Default geometry shared by the sorter and its checker.
    localparam int unsigned DEF_PORTS = 4;
    localparam int unsigned DEF_BAG_W = 8;
    localparam int unsigned DEF_ID_W  = 24;

    // Selector width for a given count (never below one bit).
    function automatic int unsigned sel_width(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/bag_port_poller.sv
module bag_port_poller #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned SEL_W     = bag_arb_pkg::sel_width(NUM_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS*WORD_W-1:0] words_i,
    output logic [WORD_W-1:0]           word_o
);

    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_PORTS - 1);

    logic [SEL_W-1:0] sel_d, sel_q;

    // Next pointer: wrap after the last port.
    always_comb begin
        if (sel_q == LAST_SEL) begin
            sel_d = '0;
        end else begin
            sel_d = sel_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    // Word of the port under the pointer.
    always_comb begin
        word_o = words_i[sel_q*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/bag_onehot_decode.sv
module bag_onehot_decode #(
    parameter int unsigned BAG_W = 8,
    parameter int unsigned IDX_W = bag_arb_pkg::sel_width(BAG_W)
) (
    input  logic [BAG_W-1:0] bag_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);

    // Only an exact power of two names a lane.
    always_comb begin
        hit_o = ($countones(bag_i) == 1);
    end

    // Index bit j is the OR of every field bit whose position has bit j set.
    for (genvar j = 0; j < IDX_W; j++) begin : g_idx
        logic [BAG_W-1:0] pick;
        for (genvar k = 0; k < BAG_W; k++) begin : g_bit
            if (((k >> j) % 2) == 1) begin : g_on
                assign pick[k] = bag_i[k];
            end else begin : g_off
                assign pick[k] = 1'b0;
            end
        end
        assign idx_o[j] = |pick;
    end

endmodule

// File: rtl/bag_lane_steer.sv
module bag_lane_steer #(
    parameter int unsigned NUM_LANES = 8,
    parameter int unsigned IDX_W     = bag_arb_pkg::sel_width(NUM_LANES)
) (
    input  logic                 hit_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic [NUM_LANES-1:0] lane_we_o
);

    // One enable per lane, raised only for a decoded hit on that lane.
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lane_we_o[l] = hit_i && (idx_i == IDX_W'(l));
    end

endmodule

// File: rtl/bag_lane_arbiter.sv
module bag_lane_arbiter #(
    parameter int unsigned NUM_PORTS = bag_arb_pkg::DEF_PORTS,
    parameter int unsigned BAG_W     = bag_arb_pkg::DEF_BAG_W,
    parameter int unsigned ID_W      = bag_arb_pkg::DEF_ID_W
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_PORTS*(BAG_W+ID_W)-1:0]  port_word_i,
    output logic [NUM_PORTS*BAG_W-1:0]         port_bag_o,
    output logic [BAG_W*ID_W-1:0]              lane_id_o,
    output logic [BAG_W-1:0]                   lane_wr_o
);

    localparam int unsigned WORD_W    = BAG_W + ID_W;
    localparam int unsigned NUM_LANES = BAG_W;
    localparam int unsigned IDX_W     = bag_arb_pkg::sel_width(NUM_LANES);

    typedef struct packed {
        logic [NUM_LANES*ID_W-1:0]  lane_id;
        logic [NUM_LANES-1:0]       lane_wr;
        logic [NUM_PORTS*BAG_W-1:0] bag;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [WORD_W-1:0]    cur_word;
    logic [BAG_W-1:0]     cur_bag;
    logic [ID_W-1:0]      cur_id;
    logic                 cur_hit;
    logic [IDX_W-1:0]     cur_idx;
    logic [NUM_LANES-1:0] lane_we;

    bag_port_poller #(
        .NUM_PORTS (NUM_PORTS),
        .WORD_W    (WORD_W)
    ) i_poller (
        .clk     (clk),
        .rst     (rst),
        .words_i (port_word_i),
        .word_o  (cur_word)
    );

    assign cur_bag = cur_word[WORD_W-1 -: BAG_W];
    assign cur_id  = cur_word[ID_W-1:0];

    bag_onehot_decode #(
        .BAG_W (BAG_W),
        .IDX_W (IDX_W)
    ) i_decode (
        .bag_i (cur_bag),
        .hit_o (cur_hit),
        .idx_o (cur_idx)
    );

    bag_lane_steer #(
        .NUM_LANES (NUM_LANES),
        .IDX_W     (IDX_W)
    ) i_steer (
        .hit_i     (cur_hit),
        .idx_i     (cur_idx),
        .lane_we_o (lane_we)
    );

    always_comb begin
        st_d         = st_q;
        st_d.lane_wr = lane_we;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (lane_we[l]) begin
                st_d.lane_id[l*ID_W +: ID_W] = cur_id;
            end
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            st_d.bag[p*BAG_W +: BAG_W] = port_word_i[p*WORD_W + ID_W +: BAG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign port_bag_o = st_q.bag;
    assign lane_id_o  = st_q.lane_id;
    assign lane_wr_o  = st_q.lane_wr;

endmodule

// File: rtl/bag_lane_arbiter_chk.sv
module bag_lane_arbiter_chk #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned BAG_W     = 8,
    parameter int unsigned ID_W      = 24
) (
    input logic                              clk,
    input logic                              rst,
    input logic [NUM_PORTS*(BAG_W+ID_W)-1:0] port_word_i,
    input logic [NUM_PORTS*BAG_W-1:0]        port_bag_o,
    input logic [BAG_W*ID_W-1:0]             lane_id_o,
    input logic [BAG_W-1:0]                  lane_wr_o
);

    localparam int unsigned WORD_W = BAG_W + ID_W;

    logic seen_q  = 1'b0;
    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b1;
            armed_q <= 1'b0;
        end else begin
            armed_q <= seen_q;
        end
    end

    logic [NUM_PORTS*BAG_W-1:0] in_bags;
    logic [BAG_W-1:0]           lane_named;
    logic                       any_legal;

    always_comb begin
        lane_named = '0;
        any_legal  = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            in_bags[p*BAG_W +: BAG_W] = port_word_i[p*WORD_W + ID_W +: BAG_W];
            if ($countones(port_bag_o[p*BAG_W +: BAG_W]) == 1) begin
                any_legal = 1'b1;
            end
            lane_named = lane_named | port_bag_o[p*BAG_W +: BAG_W];
        end
    end

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(rst)) |-> (lane_wr_o == '0 && lane_id_o == '0 && port_bag_o == '0)); // R1

    AST_WR_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> $onehot0(lane_wr_o)); // R5

    AST_BAG_MIRROR: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (port_bag_o == $past(in_bags))); // R7

    AST_NO_WR_INVALID: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !any_legal) |-> (lane_wr_o == '0)); // R8

    for (genvar l = 0; l < BAG_W; l++) begin : g_lane_chk
        AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
            (armed_q && !lane_wr_o[l]) |-> $stable(lane_id_o[l*ID_W +: ID_W])); // R6

        AST_LANE_MATCH: assert property (@(posedge clk) disable iff (rst)
            (armed_q && lane_wr_o[l]) |-> lane_named[l]); // R4
    end

endmodule

bind bag_lane_arbiter bag_lane_arbiter_chk #(
    .NUM_PORTS (NUM_PORTS),
    .BAG_W     (BAG_W),
    .ID_W      (ID_W)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .port_word_i (port_word_i),
    .port_bag_o  (port_bag_o),
    .lane_id_o   (lane_id_o),
    .lane_wr_o   (lane_wr_o)
);

// File: tb/test_bag_lane_arbiter.sv
`timescale 1ns/1ps
module test_bag_lane_arbiter;

    localparam int NP = 4;
    localparam int BW = 8;
    localparam int IW = 24;
    localparam int WW = BW + IW;
    localparam int NL = BW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP*WW-1:0]  words = '0;
    logic [NP*BW-1:0]  port_bag_o;
    logic [NL*IW-1:0]  lane_id_o;
    logic [NL-1:0]     lane_wr_o;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bag_lane_arbiter i_bag_lane_arbiter (
        .clk         (clk),
        .rst         (rst),
        .port_word_i (words),
        .port_bag_o  (port_bag_o),
        .lane_id_o   (lane_id_o),
        .lane_wr_o   (lane_wr_o)
    );

    // Behavioural reference: a rotating port number and per-lane memories.
    int          m_sel = 0;
    logic [IW-1:0] m_id  [NL];
    logic [NL-1:0] m_wr;
    logic [BW-1:0] m_bag [NP];

    initial begin
        for (int i = 0; i < NL; i++) m_id[i] = '0;
        for (int i = 0; i < NP; i++) m_bag[i] = '0;
        m_wr = '0;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0;
            m_wr  = '0;
            for (int i = 0; i < NL; i++) m_id[i] = '0;
            for (int i = 0; i < NP; i++) m_bag[i] = '0;
        end else begin
            logic [WW-1:0] w;
            w    = words[m_sel*WW +: WW];
            m_wr = '0;
            for (int k = 0; k < NL; k++) begin
                if (w[WW-1 -: BW] == BW'(1 << k)) begin
                    m_id[k] = w[IW-1:0];
                    m_wr[k] = 1'b1;
                end
            end
            for (int p = 0; p < NP; p++) m_bag[p] = words[p*WW + IW +: BW];
            m_sel = (m_sel + 1) % NP;
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [NL*IW-1:0] act, input logic [NL*IW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            logic [NL*IW-1:0] e_id;
            logic [NP*BW-1:0] e_bag;
            for (int k = 0; k < NL; k++) e_id[k*IW +: IW] = m_id[k];
            for (int p = 0; p < NP; p++) e_bag[p*BW +: BW] = m_bag[p];
            check(lane_wr_o == m_wr, "R2 R4 R5 R8 strobes", NL*IW'(lane_wr_o), NL*IW'(m_wr));
            check(lane_id_o == e_id, "R3 R6 lane ids", lane_id_o, e_id);
            check(port_bag_o == e_bag, "R7 gap mirror", NL*IW'(port_bag_o), NL*IW'(e_bag));
        end
    end

    function automatic logic [WW-1:0] mk(input logic [BW-1:0] b, input logic [IW-1:0] id);
        return {b, id};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        // Busy inputs during reset must not leak out (R1).
        for (int p = 0; p < NP; p++) words[p*WW +: WW] = mk(8'h04, IW'(p + 7));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(lane_wr_o == '0 && lane_id_o == '0 && port_bag_o == '0, "R1 reset clear",
              lane_id_o, '0);
        words = '0;
        rst   = 1'b0;
        cmp_en = 1'b1;

        // Every legal gap on every port (R2, R3, R4).
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < NL; k++) begin
                words = '0;
                words[p*WW +: WW] = mk(BW'(1 << k), IW'(24'h100000 + p*16 + k));
                repeat (4) @(negedge clk);
            end
        end

        // Non one-hot gaps, including zero words (R8).
        words = '0;
        repeat (4) @(negedge clk);
        for (int p = 0; p < NP; p++) words[p*WW +: WW] = mk(8'h03, IW'(24'hABC000 + p));
        repeat (4) @(negedge clk);
        for (int p = 0; p < NP; p++) words[p*WW +: WW] = mk(8'hFF, IW'(24'h5A5A00 + p));
        repeat (4) @(negedge clk);
        for (int p = 0; p < NP; p++) words[p*WW +: WW] = mk(8'h81, IW'(24'h00FF00 + p));
        repeat (4) @(negedge clk);
        for (int p = 0; p < NP; p++) words[p*WW +: WW] = mk(8'h00, IW'(24'h123400 + p));
        repeat (4) @(negedge clk);
        check(lane_wr_o == '0, "R8 no strobe for illegal gap", NL*IW'(lane_wr_o), '0);

        // Single-port service bound (R9).
        for (int p = 0; p < NP; p++) begin
            int  n;
            bit  found;
            words = '0;
            repeat (2 + p) @(negedge clk);
            words[p*WW +: WW] = mk(8'h10, IW'(24'h900000 + p));
            n = 0;
            found = 1'b0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                n++;
                if (lane_wr_o[4]) begin
                    found = 1'b1;
                    break;
                end
            end
            check(found && n <= 4, "R9 service within four edges", n, 4);
            check(lane_id_o[4*IW +: IW] == IW'(24'h900000 + p), "R4 lane 4 id",
                  lane_id_o[4*IW +: IW], IW'(24'h900000 + p));
            words = '0;
        end

        // Mixed traffic.
        for (int c = 0; c < 2000; c++) begin
            for (int p = 0; p < NP; p++) begin
                if (($urandom % 3) != 0) begin
                    logic [BW-1:0] b;
                    b = (($urandom % 4) != 0) ? BW'(1 << ($urandom % NL)) : BW'($urandom);
                    words[p*WW +: WW] = mk(b, IW'($urandom));
                end
            end
            @(negedge clk);
        end

        // Reset in the middle of traffic, then resume (R1, R2).
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(lane_wr_o == '0 && lane_id_o == '0 && port_bag_o == '0, "R1 mid-run reset",
              lane_id_o, '0);
        rst = 1'b0;
        for (int c = 0; c < 300; c++) begin
            int p;
            p = $urandom % NP;
            words[p*WW +: WW] = mk(BW'(1 << ($urandom % NL)), IW'($urandom));
            @(negedge clk);
        end

        cmp_en = 1'b0;
        done   = 1'b1;
        summary();
        $finish;
    end

endmodule